// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer for 18-bit words whose storage depth is a power-of-two parameter between 64 and 4096. Writes are taken on the write clock and reads on the read clock. The two clocks are independent. Both enables are active low. An active-low asynchronous reset returns the block to its empty state.

Five active-low status outputs report the fill level. Empty and almost-empty belong to the read domain. Full, half-full and almost-full belong to the write domain. A separate offset block supplies the two almost-flag thresholds as inputs. The read and write pointers cross between the domains as Gray code through two-flop synchronisers. As a result, a flag can report empty or full for a few cycles after the opposite side has already moved.

Each accepted read loads a registered output word. That word is kept when a read attempt is refused. A retransmit pulse rewinds reading to physical location zero. The data output is high impedance while the output enable is deasserted.

Top module: `fifo_dual_clk`

## Requirements
- R1: Words leave the FIFO on `rdData` in the order they were accepted. Each word is 18 bits wide, and `DEPTH` (default 64) is a power of two from 64 to 4096.
- R2: On a rising `wrClk` edge where `wrEnN` is 0 and `fullN` is 1, the word on `wrData` is stored.
- R3: `emptyN` is 0 while the read domain sees no stored word, and is updated only on rising `rdClk` edges. While it is 0, reads are refused whatever `rdEnN` is. With one common clock, a write on edge t raises `emptyN` on edge t+3.
- R4: `fullN` is 0 while the write domain sees DEPTH stored words, and is updated only on rising `wrClk` edges. While it is 0, writes are refused whatever `wrEnN` is. With one common clock, a read on edge t releases `fullN` on edge t+3.
- R5: A read attempt that is refused leaves `rdData` unchanged, so it keeps the last word read.
- R6: While `rstN` is 0, the outputs are: `emptyN`=0, `almostEmptyN`=0, `fullN`=1, `halfFullN`=1, `almostFullN`=1, and `rdData`=0 when `oeN` is 0.
- R7: `almostEmptyN` is 0 when the read-domain word count is less than or equal to `emptyOffset`. It is updated on `rdClk`.
- R8: `almostFullN` is 0 when the number of free locations seen in the write domain is less than or equal to `fullOffset`. It is updated on `wrClk`.
- R9: `halfFullN` is 0 when the write-domain word count is greater than DEPTH/2. It is updated on `wrClk`.
- R10: When `retransmit` is 1 on a rising `rdClk` edge, the read pointer returns to location 0 and no read occurs on that edge. The next accepted read returns the first word written since reset.
- R11: While `oeN` is 1, `rdData` is high impedance. The held output word is not disturbed and reappears when `oeN` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | 18 | Word to store |
| rdEnN | input | 1 | Read enable, active low |
| retransmit | input | 1 | Rewind the read pointer to location 0 |
| oeN | input | 1 | Output enable, active low |
| emptyOffset | input | $clog2(DEPTH)+1 | Almost-empty threshold in words |
| fullOffset | input | $clog2(DEPTH)+1 | Almost-full threshold in free locations |
| rdData | output | 18 | Registered read word, tri-stated by `oeN` |
| emptyN | output | 1 | Empty, active low |
| fullN | output | 1 | Full, active low |
| halfFullN | output | 1 | More than half full, active low |
| almostEmptyN | output | 1 | Almost empty, active low |
| almostFullN | output | 1 | Almost full, active low |

## Verification
The bench runs both domains from one clock, so every latency is a fixed count of edges. A read refreshes `rdData` on the same edge that accepts it. A pointer change made on edge t reaches the flags of the other domain on edge t+3: one edge for the Gray register, two for the synchroniser, and the flag register samples the synchroniser output one edge after that. Flags that depend only on the local pointer change on the local edge itself. The reference model keeps the last three pointer values of each side and forms each flag from the local pointer after edge t and the remote pointer after edge t-3. It drives inputs and compares outputs at the falling edge, so every comparison falls half a cycle after the register update it expects.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  localparam int WORD_W = 18;
  localparam int PTR_MAX_W = 13;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic store;
    logic fetch;
  } memStrobe_t;

  function automatic logic [PTR_MAX_W-1:0] grayToBin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          retransmit,
  input  logic [PW-1:0] emptyOffset,
  input  logic [PW-1:0] fullOffset,
  output memStrobe_t    stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          fullN,
  output logic          halfFullN,
  output logic          almostEmptyN,
  output logic          almostFullN
);

  localparam logic [PW-1:0] FULL_COUNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_COUNT = PW'(DEPTH / 2);

  logic [PW-1:0] wrBin, wrGray, wrNext;
  logic [PW-1:0] rdBin, rdGray, rdNext;
  logic [PW-1:0] wSyncGray, rSyncGray;
  logic [PW-1:0] wSyncBin, rSyncBin;
  logic [PW-1:0] wrCount, rdCount;

  // Transfer strobes gated by the registered flags
  always_comb begin
    stb.store = !wrEnN && fullN;
    stb.fetch = !rdEnN && emptyN && !retransmit;
  end

  assign wrNext  = wrBin + PW'(stb.store);
  assign rdNext  = retransmit ? '0 : (rdBin + PW'(stb.fetch));
  assign wrAddr  = wrBin[AW-1:0];
  assign rdAddr  = rdBin[AW-1:0];

  // Cross-domain pointer copies
  fifo_sync2 #(.WIDTH(PW)) i_syncWrToRd (
    .clk (rdClk),
    .rstN(rstN),
    .d   (wrGray),
    .q   (wSyncGray)
  );

  fifo_sync2 #(.WIDTH(PW)) i_syncRdToWr (
    .clk (wrClk),
    .rstN(rstN),
    .d   (rdGray),
    .q   (rSyncGray)
  );

  assign wSyncBin = PW'(grayToBin(PTR_MAX_W'(wSyncGray)));
  assign rSyncBin = PW'(grayToBin(PTR_MAX_W'(rSyncGray)));
  assign wrCount  = wrNext - rSyncBin;
  assign rdCount  = wSyncBin - rdNext;

  // Write domain
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      fullN       <= 1'b1;
      halfFullN   <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      wrBin       <= wrNext;
      wrGray      <= wrNext ^ (wrNext >> 1);
      fullN       <= (wrCount != FULL_COUNT);
      halfFullN   <= !(wrCount > HALF_COUNT);
      almostFullN <= !((FULL_COUNT - wrCount) <= fullOffset);
    end
  end

  // Read domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin        <= '0;
      rdGray       <= '0;
      emptyN       <= 1'b0;
      almostEmptyN <= 1'b0;
    end else begin
      rdBin        <= rdNext;
      rdGray       <= rdNext ^ (rdNext >> 1);
      emptyN       <= (rdCount != '0);
      almostEmptyN <= !(rdCount <= emptyOffset);
    end
  end

  assert_no_write_full_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrBin));

  assert_no_read_empty_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    (!emptyN && !retransmit) |=> $stable(rdBin));

  assert_gray_step_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> $onehot0(wrGray ^ $past(wrGray)));

  assert_rewind_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    retransmit |=> (rdBin == '0));

  assert_full_implies_af_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);

  assert_empty_implies_ae_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);

endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = WORD_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  memStrobe_t        stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] qReg
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.store) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      qReg <= '0;
    end else if (stb.fetch) begin
      qReg <= mem[rdAddr];
    end
  end

  assert_hold_q_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.fetch |=> $stable(qReg));

endmodule

// File: rtl/fifo_dual_clk.sv
module fifo_dual_clk
  import fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DATA_W = WORD_W
) (
  input  logic                   wrClk,
  input  logic                   rdClk,
  input  logic                   rstN,
  input  logic                   wrEnN,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   rdEnN,
  input  logic                   retransmit,
  input  logic                   oeN,
  input  logic [$clog2(DEPTH):0] emptyOffset,
  input  logic [$clog2(DEPTH):0] fullOffset,
  output logic [DATA_W-1:0]      rdData,
  output logic                   emptyN,
  output logic                   fullN,
  output logic                   halfFullN,
  output logic                   almostEmptyN,
  output logic                   almostFullN
);

  localparam int AW = $clog2(DEPTH);

  memStrobe_t        stb;
  logic [AW-1:0]     wrAddr, rdAddr;
  logic [DATA_W-1:0] qOut;

  fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .wrEnN       (wrEnN),
    .rdEnN       (rdEnN),
    .retransmit  (retransmit),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .emptyN      (emptyN),
    .fullN       (fullN),
    .halfFullN   (halfFullN),
    .almostEmptyN(almostEmptyN),
    .almostFullN (almostFullN)
  );

  fifo_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_datapath (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .stb   (stb),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .qReg  (qOut)
  );

  assign rdData = oeN ? {DATA_W{1'bz}} : qOut;

endmodule

// File: tb/test_fifo_dual_clk.sv
`timescale 1ns/1ps
module test_fifo_dual_clk;

  localparam int D  = 64;
  localparam int M  = 2 * D;
  localparam int OW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnN = 1'b1, rdEnN = 1'b1, retransmit = 1'b0, oeN = 1'b0;
  logic [17:0] wrData = '0;
  logic [OW-1:0] emptyOffset = OW'(4), fullOffset = OW'(6);
  logic [17:0] rdData;
  logic emptyN, fullN, halfFullN, almostEmptyN, almostFullN;

  always #2 clk = ~clk;

  fifo_dual_clk #(.DEPTH(D)) i_fifo_dual_clk (
    .wrClk(clk), .rdClk(clk), .rstN(rstN),
    .wrEnN(wrEnN), .wrData(wrData), .rdEnN(rdEnN),
    .retransmit(retransmit), .oeN(oeN),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .rdData(rdData), .emptyN(emptyN), .fullN(fullN),
    .halfFullN(halfFullN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN)
  );

  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  // Reference model state
  int w, r;
  int wh [4];
  int rh [4];
  logic [17:0] store [D];
  logic [17:0] expQ;
  bit expEmptyN, expFullN, expHfN, expAeN, expAfN;

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    w = 0; r = 0;
    for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
    expQ = '0;
    expEmptyN = 0; expAeN = 0; expFullN = 1; expHfN = 1; expAfN = 1;
  endtask

  task automatic modelEdge(input bit we, input bit re, input bit rt, input logic [17:0] d);
    bit wOk, rOk;
    int cR, cW;
    wOk = we && expFullN;
    rOk = re && expEmptyN && !rt;
    if (wOk) begin store[w % D] = d; w = (w + 1) % M; end
    if (rt) r = 0;
    else if (rOk) begin expQ = store[r % D]; r = (r + 1) % M; end
    for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
    wh[0] = w; rh[0] = r;
    cR = (wh[3] - r + M) % M;
    cW = (w - rh[3] + M) % M;
    expEmptyN = (cR != 0);
    expAeN    = !(cR <= int'(emptyOffset));
    expFullN  = (cW != D);
    expHfN    = !(cW > D / 2);
    expAfN    = !((D - cW) <= int'(fullOffset));
  endtask

  task automatic compareAll();
    if (!oeN) check("R1", rdData, expQ);
    check("R3", 18'(emptyN), 18'(expEmptyN));
    check("R4", 18'(fullN), 18'(expFullN));
    check("R9", 18'(halfFullN), 18'(expHfN));
    check("R7", 18'(almostEmptyN), 18'(expAeN));
    check("R8", 18'(almostFullN), 18'(expAfN));
  endtask

  task automatic step(input bit we, input bit re, input bit rt, input logic [17:0] d);
    wrEnN = !we; rdEnN = !re; retransmit = rt; wrData = d;
    @(posedge clk);
    modelEdge(we, re, rt, d);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wrEnN = 1'b1; rdEnN = 1'b1; retransmit = 1'b0;
    @(negedge clk); @(negedge clk);
    modelReset();
    check("R6", rdData, 18'h0);
    check("R6", 18'({emptyN, almostEmptyN, fullN, halfFullN, almostFullN}), 18'b00111);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();

    // R2: a few writes become visible to the read side
    for (int i = 0; i < 3; i++) step(1, 0, 0, 18'h1000 + 18'(i));
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    check("R2", 18'(emptyN), 18'h1);

    // Read them out plus two refused reads (R5)
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0);
    check("R5", rdData, 18'h1002);

    // Fill past full (R4)
    for (int i = 0; i < D + 6; i++) step(1, 0, 0, 18'h2000 + 18'(i));
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    check("R4", 18'(fullN), 18'h0);

    // Mixed traffic with different thresholds
    emptyOffset = OW'(10); fullOffset = OW'(20);
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, 18'h3000 + 18'(i));

    // Drain
    for (int i = 0; i < D + 10; i++) step(0, 1, 0, '0);

    // R11: output enable
    for (int i = 0; i < 2; i++) step(1, 0, 0, 18'h3AAA);
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    step(0, 1, 0, '0);
    oeN = 1'b1;
    step(0, 0, 0, '0);
    vectors++;
    if (!(rdData === 18'bz || rdData === 18'h0)) begin
      fails++;
      $display("FAIL R11: actual %h expected high impedance", rdData);
    end
    oeN = 1'b0;
    step(0, 0, 0, '0);
    check("R11", rdData, 18'h3AAA);

    // R10: retransmit after reset
    doReset();
    for (int i = 0; i < 10; i++) step(1, 0, 0, 18'h4000 + 18'(i));
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    step(0, 1, 1, '0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    step(0, 1, 0, '0);
    check("R10", rdData, 18'h4000);
    for (int i = 0; i < 12; i++) step(0, 1, 0, '0);

    finishRun();
  end

endmodule